// File: doc/BRIEF.md
# Phase-Accumulator Sine/Cosine Generator

This block is a numerically controlled oscillator. Each accepted sample adds a frequency step to a 32-bit phase register. The top 16 bits of that register, plus a 16-bit phase offset, form the angle of the sample. A fully pipelined rotation engine turns that angle into a signed cosine and sine pair. The register width alone sets the frequency resolution, so the output frequency is Fclk·step/2^32. The narrower angle only limits phase noise. It has no effect on the average frequency.

The angle is split into a quadrant (its top two bits) and a residual below 90°. The residual drives sixteen shift-and-add rotation stages. Each stage turns the vector by ±atan(2^-i) and steers toward zero residual angle. The stages work on an I/Q path that is 16 bits wide plus 4 guard bits. The start vector is pre-scaled by the inverse of the rotation gain, so no multiplier follows the stages. The output stage swaps and negates the pair according to the quadrant, then rounds the result to 16 bits. A one-cycle carry pulse from the phase register can be used elsewhere as a fractional-rate clock enable.

Top module: `nco_cordic_gen`

## Requirements
- R1: While rst_ni is low, and after its release until the first result, valid_o, wrap_o, cos_o and sin_o are all 0, and the phase register is 0.
- R2: On each rising edge with valid_i high, the phase register becomes (register + freq_i) mod 2^32. With valid_i low it holds its value.
- R3: The angle of a sample is bits [31:16] of the updated phase register plus phase_i, mod 2^16. 2^16 angle units make one full turn.
- R4: For a sample of angle a, cos_o and sin_o (16-bit two's complement) are within ±6 of round(32000·cos(2πa/65536)) and round(32000·sin(2πa/65536)). The value -32768 never appears.
- R5: Each accepted sample yields exactly one cycle of valid_o, in input order. valid_o is high in the cycle after the 18th rising edge, counting the edge that sampled valid_i as the first (18 register stages).
- R6: wrap_o is high for the one cycle after an accepted sample whose addition carried out of bit 31. It is low after every other cycle, including cycles with valid_i low and samples with freq_i = 0.
- R7: The quadrant fold is exact at the boundaries. Angles 0x0000, 0x4000, 0x8000 and 0xC000 give (32000,0), (0,32000), (-32000,0) and (0,-32000), and angles just either side of a boundary meet the R4 bound.
- R8: With freq_i = 0, the phase register does not move, so the output depends only on phase_i.
- R9: While valid_o is low, cos_o and sin_o hold the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept a sample: advance phase and launch a rotation |
| freq_i | input | 32 | Phase step per accepted sample |
| phase_i | input | 16 | Phase offset added to the angle of this sample |
| valid_o | output | 1 | cos_o and sin_o carry a new result |
| cos_o | output | 16 | Signed cosine sample |
| sin_o | output | 16 | Signed sine sample |
| wrap_o | output | 1 | One-cycle pulse when the phase register overflows |

## Verification
The checker assumes that freq_i and phase_i are defined in every cycle in which valid_i is high. It assumes that reset is released with valid_i low, so the outstanding-sample count starts from zero. The residual-angle bound assumes the default stage count and angle scaling, under which sixteen stages converge to within a few guard-scaled units. The stimulus keeps valid_i low through reset and drives every input at the falling edge with defined values. It covers step values that carry on every sample, on alternate samples, or never.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic [1:0] {
    QUAD_0   = 2'd0,
    QUAD_90  = 2'd1,
    QUAD_180 = 2'd2,
    QUAD_270 = 2'd3
  } quad_e;

  // atan(2^-idx) expressed with 2^circ_w units per full turn
  function automatic longint atan_units(input int idx, input int circ_w);
    longint base;
    case (idx)
      0:  base = 131072;
      1:  base = 77376;
      2:  base = 40883;
      3:  base = 20753;
      4:  base = 10417;
      5:  base = 5213;
      6:  base = 2607;
      7:  base = 1304;
      8:  base = 652;
      9:  base = 326;
      10: base = 163;
      11: base = 81;
      12: base = 41;
      13: base = 20;
      14: base = 10;
      15: base = 5;
      default: base = longint'(166886) >>> idx;
    endcase
    if (circ_w >= 20) return base <<< (circ_w - 20);
    else              return base >>> (20 - circ_w);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int ANG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [ACC_W-1:0] freq_i,
  input  logic [ANG_W-1:0] phase_i,
  output logic             v_o,
  output logic [ANG_W-1:0] ang_o,
  output logic             wrap_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, freq_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      v_o    <= 1'b0;
      ang_o  <= '0;
      wrap_o <= 1'b0;
    end else begin
      v_o    <= valid_i;
      wrap_o <= valid_i & sum[ACC_W];
      if (valid_i) begin
        acc_q <= sum[ACC_W-1:0];
        ang_o <= sum[ACC_W-1 -: ANG_W] + phase_i;
      end
    end
  end

endmodule

// File: rtl/nco_cordic_stage.sv
module nco_cordic_stage #(
  parameter int DW  = 20,
  parameter int ZW  = 20,
  parameter int IDX = 0,
  parameter logic signed [ZW-1:0] ATAN = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 v_i,
  input  logic [1:0]           q_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic                 v_o,
  output logic [1:0]           q_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);

  logic signed [DW-1:0] xs, ys;
  logic                 neg;

  assign xs  = x_i >>> IDX;
  assign ys  = y_i >>> IDX;
  assign neg = z_i[ZW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o <= 1'b0;
      q_o <= '0;
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        q_o <= q_i;
        if (neg) begin
          x_o <= x_i + ys;
          y_o <= y_i - xs;
          z_o <= z_i + ATAN;
        end else begin
          x_o <= x_i - ys;
          y_o <= y_i + xs;
          z_o <= z_i - ATAN;
        end
      end
    end
  end

endmodule

// File: rtl/nco_quad_fold.sv
module nco_quad_fold #(
  parameter int DW    = 20,
  parameter int OUT_W = 16,
  parameter int GUARD = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    v_i,
  input  logic [1:0]              q_i,
  input  logic signed [DW-1:0]    x_i,
  input  logic signed [DW-1:0]    y_i,
  output logic                    v_o,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o
);

  import nco_pkg::*;

  localparam logic signed [DW-1:0] RND = DW'(1 << (GUARD - 1));

  logic signed [OUT_W-1:0] xr, yr, c_d, s_d;
  quad_e                   quad;

  assign xr   = OUT_W'((x_i + RND) >>> GUARD);
  assign yr   = OUT_W'((y_i + RND) >>> GUARD);
  assign quad = quad_e'(q_i);

  always_comb begin
    unique case (quad)
      QUAD_0:   begin c_d = xr;  s_d = yr;  end
      QUAD_90:  begin c_d = -yr; s_d = xr;  end
      QUAD_180: begin c_d = -xr; s_d = -yr; end
      default:  begin c_d = yr;  s_d = -xr; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o   <= 1'b0;
      cos_o <= '0;
      sin_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        cos_o <= c_d;
        sin_o <= s_d;
      end
    end
  end

endmodule

// File: rtl/nco_cordic_gen.sv
module nco_cordic_gen #(
  parameter int ACC_W    = 32,
  parameter int ANG_W    = 16,
  parameter int GUARD    = 4,
  parameter int OUT_W    = 16,
  parameter int N_STAGES = 16,
  parameter int AMP      = 32000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [ACC_W-1:0]        freq_i,
  input  logic [ANG_W-1:0]        phase_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o,
  output logic                    wrap_o
);

  localparam int DW     = OUT_W + GUARD;
  localparam int ZW     = ANG_W + GUARD;
  localparam int RES_W  = ANG_W - 2;
  localparam longint X0_L = (longint'(AMP) * (longint'(1) << GUARD) * 10000) / 16468;
  localparam logic signed [DW-1:0] X0 = DW'(X0_L);

  logic             a_v;
  logic [ANG_W-1:0] a_ang;

  nco_phase_acc #(.ACC_W(ACC_W), .ANG_W(ANG_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .freq_i (freq_i),
    .phase_i(phase_i),
    .v_o    (a_v),
    .ang_o  (a_ang),
    .wrap_o (wrap_o)
  );

  logic                 st_v [N_STAGES+1];
  logic [1:0]           st_q [N_STAGES+1];
  logic signed [DW-1:0] st_x [N_STAGES+1];
  logic signed [DW-1:0] st_y [N_STAGES+1];
  logic signed [ZW-1:0] st_z [N_STAGES+1];

  assign st_v[0] = a_v;
  assign st_q[0] = a_ang[ANG_W-1 -: 2];
  assign st_x[0] = X0;
  assign st_y[0] = '0;
  assign st_z[0] = ZW'({a_ang[RES_W-1:0], {GUARD{1'b0}}});

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    localparam logic signed [ZW-1:0] AT = ZW'(nco_pkg::atan_units(i, ZW));
    nco_cordic_stage #(.DW(DW), .ZW(ZW), .IDX(i), .ATAN(AT)) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .v_i   (st_v[i]),
      .q_i   (st_q[i]),
      .x_i   (st_x[i]),
      .y_i   (st_y[i]),
      .z_i   (st_z[i]),
      .v_o   (st_v[i+1]),
      .q_o   (st_q[i+1]),
      .x_o   (st_x[i+1]),
      .y_o   (st_y[i+1]),
      .z_o   (st_z[i+1])
    );
  end

  // residual angle after the last stage; observed by the checker only
  logic signed [ZW-1:0] resid_z;
  assign resid_z = st_z[N_STAGES];

  nco_quad_fold #(.DW(DW), .OUT_W(OUT_W), .GUARD(GUARD)) u_fold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .v_i   (st_v[N_STAGES]),
    .q_i   (st_q[N_STAGES]),
    .x_i   (st_x[N_STAGES]),
    .y_i   (st_y[N_STAGES]),
    .v_o   (valid_o),
    .cos_o (cos_o),
    .sin_o (sin_o)
  );

endmodule

// File: rtl/nco_cordic_gen_chk.sv
module nco_cordic_gen_chk #(
  parameter int ACC_W    = 32,
  parameter int ANG_W    = 16,
  parameter int GUARD    = 4,
  parameter int OUT_W    = 16,
  parameter int N_STAGES = 16
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          valid_i,
  input logic [ACC_W-1:0]              freq_i,
  input logic                          valid_o,
  input logic signed [OUT_W-1:0]       cos_o,
  input logic signed [OUT_W-1:0]       sin_o,
  input logic                          wrap_o,
  input logic signed [ANG_W+GUARD-1:0] resid_i
);

  localparam int LAT = N_STAGES + 2;
  localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  logic [31:0] n_in, n_out;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_in  <= '0;
      n_out <= '0;
    end else begin
      if (valid_i) n_in  <= n_in + 32'd1;
      if (valid_o) n_out <= n_out + 32'd1;
    end
  end

  // R5
  in_flight_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_in - n_out) <= 32'(LAT));

  // R5
  no_orphan_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (n_in != n_out));

  // R6
  wrap_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> $past(valid_i));

  // R6
  zero_step_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && ($past(freq_i) == '0)) |-> !wrap_o);

  // R4
  out_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cos_o != MOST_NEG && sin_o != MOST_NEG));

  // R4
  resid_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resid_i < 64) && (resid_i > -64));

  // R9
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> (!valid_o |-> ($stable(cos_o) && $stable(sin_o))));

endmodule

bind nco_cordic_gen nco_cordic_gen_chk #(
  .ACC_W(ACC_W), .ANG_W(ANG_W), .GUARD(GUARD), .OUT_W(OUT_W), .N_STAGES(N_STAGES)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .freq_i (freq_i),
  .valid_o(valid_o),
  .cos_o  (cos_o),
  .sin_o  (sin_o),
  .wrap_o (wrap_o),
  .resid_i(resid_z)
);

// File: tb/nco_cordic_gen_test.sv
module nco_cordic_gen_test;

  localparam int  TOL  = 6;
  localparam int  LATE = 17;
  localparam real PI   = 3.14159265358979;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               valid_i = 1'b0;
  logic [31:0]        freq_i = '0;
  logic [15:0]        phase_i = '0;
  logic               valid_o, wrap_o;
  logic signed [15:0] cos_o, sin_o;

  always #2.5 clk = ~clk;

  nco_cordic_gen uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .valid_i(valid_i),
    .freq_i (freq_i),
    .phase_i(phase_i),
    .valid_o(valid_o),
    .cos_o  (cos_o),
    .sin_o  (sin_o),
    .wrap_o (wrap_o)
  );

  int          n_chk = 0, n_bad = 0, cyc = 0;
  bit          done = 1'b0;
  logic [31:0] acc_m = '0;
  int          exp_c_q[$], exp_s_q[$], exp_t_q[$];
  string       tag_q[$];
  int          last_c = 0, last_s = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit near(input int a, input int b);
    return (a - b <= TOL) && (b - a <= TOL);
  endfunction

  task automatic send(input logic [31:0] f, input logic [15:0] p, input string tag);
    logic [32:0] s;
    logic [15:0] a;
    real         th;
    valid_i = 1'b1; freq_i = f; phase_i = p;
    @(posedge clk);
    s     = {1'b0, acc_m} + {1'b0, f};
    acc_m = s[31:0];
    a     = acc_m[31:16] + p;
    th    = 2.0 * PI * real'(a) / 65536.0;
    @(negedge clk);
    exp_c_q.push_back(int'(32000.0 * $cos(th)));
    exp_s_q.push_back(int'(32000.0 * $sin(th)));
    exp_t_q.push_back(cyc);
    tag_q.push_back(tag);
    chk(wrap_o == s[32], "R6 wrap", int'(wrap_o), int'(s[32]));
    valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    valid_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(wrap_o == 1'b0, "R6 idle", int'(wrap_o), 0);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid_o) begin
        if (exp_c_q.size() == 0) begin
          chk(1'b0, "R5 unexpected output", 1, 0);
        end else begin
          int    ec, es, et;
          string tg;
          ec = exp_c_q.pop_front(); es = exp_s_q.pop_front();
          et = exp_t_q.pop_front(); tg = tag_q.pop_front();
          chk(near(int'(cos_o), ec), {tg, " cos"}, int'(cos_o), ec);
          chk(near(int'(sin_o), es), {tg, " sin"}, int'(sin_o), es);
          chk(cyc - et == LATE, "R5 latency", cyc - et, LATE);
        end
        last_c = int'(cos_o);
        last_s = int'(sin_o);
      end else begin
        chk(int'(cos_o) == last_c && int'(sin_o) == last_s, "R9 hold",
            int'(cos_o), last_c);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      chk(!valid_o && !wrap_o && cos_o == 0 && sin_o == 0, "R1 reset",
          int'(cos_o) + int'(sin_o) + int'(valid_o) + int'(wrap_o), 0);
    end
    rst_n = 1'b1;
    idle(3);
    chk(!valid_o && cos_o == 0, "R1 after release", int'(cos_o), 0);

    // R7 quadrant boundaries with zero step (phase register stays at 0: R1, R8)
    send(32'h0, 16'h0000, "R7 0deg");
    send(32'h0, 16'h4000, "R7 90deg");
    send(32'h0, 16'h8000, "R7 180deg");
    send(32'h0, 16'hC000, "R7 270deg");
    send(32'h0, 16'h3FFF, "R7 below90");
    send(32'h0, 16'h4001, "R7 above90");
    send(32'h0, 16'hFFFF, "R7 below360");
    send(32'h0, 16'h2000, "R8 45deg");
    idle(25);
    send(32'h0, 16'h2000, "R8 repeat");
    send(32'h0, 16'h1234, "R8 offset");

    // R2/R3 steady tone, 1/256 turn per sample, carries every 256 samples
    for (int k = 0; k < 300; k++) send(32'h0100_0000, 16'h0000, "R2 tone");
    // R3 offset applied on a moving phase
    for (int k = 0; k < 40; k++) send(32'h0100_0000, 16'h6000, "R3 offset");

    // R6 half-turn steps with gaps: carry on alternate samples
    for (int k = 0; k < 20; k++) begin
      send(32'h8000_0000, 16'h0100, "R6 half");
      idle(1);
    end
    // R6 near-full step: carry on almost every sample
    for (int k = 0; k < 20; k++) send(32'hFFFF_FFFF, 16'h0000, "R6 full");

    // R2 hold across gaps, R4 random angles
    for (int k = 0; k < 400; k++) begin
      send($urandom, 16'($urandom), "R4 random");
      if ($urandom_range(3) == 0) idle(int'($urandom_range(4)));
    end

    idle(30);
    chk(exp_c_q.size() == 0, "R5 drained", exp_c_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule